// File: doc/BRIEF.md
# Asynchronous Bus Slave with Wait Merge

This block is a register peripheral that hangs off a microcontroller's external asynchronous I/O bus. The processor reaches it through two chip-select regions. It qualifies a cycle from active-low chip-select, read-strobe and write-strobe inputs. It holds eight 16-bit registers that can be written by byte lane. The primary region uses 16-bit accesses. The secondary region runs in 8-bit mode, where address bit A0 chooses the byte.

The block also owns the processor's shared active-low wait line. It merges an inverted wait request from a neighbouring peripheral with its own stretch request. Its own stretch is raised for a fixed number of local clocks at the start of each primary-region access, because only that region honours wait. Read data is driven onto the bidirectional bus only while a read is qualified. Writes are committed once the write strobe deasserts, after the strobe has been brought into the local clock domain.

Top module: `abus_slave`

## Requirements
- R1: A cycle is recognised only when a chip select (`cs_pri_n` or `cs_sec_n`, low) and a strobe (`rd_n` or `wr_n`, low) are active together. A write strobe with both chip selects high changes no register.
- R2: `reg_sel` (bus address bits A23..A21) picks one of eight registers, with value k selecting register k, in both regions.
- R3: In the primary region, a write with `lane_lo_n` low updates bits 7:0 from `dbus[7:0]`, and a write with `lane_hi_n` low updates bits 15:8 from `dbus[15:8]`. A byte whose lane is high keeps its value.
- R4: In the primary region, a write with both lane selects high leaves the register unchanged.
- R5: In the secondary region, `dbus[7:0]` is written into the low byte when `a0` is 0 and into the high byte when `a0` is 1, and the lane selects are ignored. A read returns that byte on bits 7:0 with bits 15:8 zero.
- R6: A primary-region read drives the full 16-bit register on `dbus` while the chip select and the read strobe are both low.
- R7: Write data is committed within three local clocks of `wr_n` rising, and reads afterwards return it.
- R8: `wait_n` is low whenever `ext_wait_n` is low.
- R9: Each primary-region access pulls `wait_n` low for exactly STRETCH_CYC local clocks (default 4), once per access however long the strobe is held.
- R10: Secondary-region accesses never cause an internal stretch.
- R11: Reset clears every register to zero and leaves `wait_n` equal to `ext_wait_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_pri_n | input | 1 | Primary region chip select, active low, 16-bit, wait honoured |
| cs_sec_n | input | 1 | Secondary region chip select, active low, 8-bit mode |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| lane_lo_n | input | 1 | Low byte lane select (bits 7:0), active low |
| lane_hi_n | input | 1 | High byte lane select (bits 15:8), active low |
| reg_sel | input | 3 | Register select from address bits A23..A21 |
| a0 | input | 1 | Address bit A0, byte pick in 8-bit mode |
| dbus | inout | 16 | Bidirectional data bus |
| ext_wait_n | input | 1 | Wait request from neighbouring peripheral, active low |
| wait_n | output | 1 | Merged wait to processor, active low |

## Verification
The embedded assertions check the following on every clock: the stretch counter never exceeds its limit and never restarts without a fresh access edge; a register byte whose lane was not written stays stable; and the merged wait equals the external wait right after reset. Only the directed scenarios can show the rest. Those cover lane masking and 8-bit byte steering observed through read-back, that writes without a chip select are dropped, that a stretch lasts exactly the set number of clocks per primary access and never occurs for the secondary region, and that an external wait request passes through.

// File: rtl/abus_pkg.sv
`timescale 1ns/1ps
package abus_pkg;
  localparam int SEL_W  = 3;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic             pri;
    logic             sec;
    logic [SEL_W-1:0] idx;
    logic             a0;
    logic [1:0]       lane;
    logic [WORD_W-1:0] data;
  } wr_snap_t;
endpackage

// File: rtl/abus_sync.sv
`timescale 1ns/1ps
module abus_sync #(
  parameter int         WIDTH     = 1,
  parameter logic [0:0] RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {WIDTH{RESET_VAL}};
      q_sync <= {WIDTH{RESET_VAL}};
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/abus_stretch.sv
`timescale 1ns/1ps
module abus_stretch #(
  parameter int STRETCH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_async,
  output logic stretch
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 1);

  logic             acc_s;
  logic             acc_d;
  logic             start;
  logic [CNT_W-1:0] cnt_q;

  abus_sync #(.WIDTH(1), .RESET_VAL(1'b0)) i_acc_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(acc_async),
    .q_sync (acc_s)
  );

  assign start = acc_s & ~acc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      acc_d <= acc_s;
      if (start)
        cnt_q <= CNT_W'(STRETCH_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign stretch = (cnt_q != '0);

  AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(STRETCH_CYC)); // R9
  AST_STRETCH_NO_SELFSTART: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !start) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/abus_regfile.sv
`timescale 1ns/1ps
module abus_regfile #(
  parameter int SEL_W  = 3,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int HALF_W   = WORD_W / 2;

  logic [WORD_W-1:0] regs_q [NUM_REGS];

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar b = 0; b < 2; b++) begin : g_byte
        always_ff @(posedge clk) begin
          if (rst)
            regs_q[r][b*HALF_W +: HALF_W] <= '0;
          else if (wr_en && wr_idx == SEL_W'(r) && wr_be[b])
            regs_q[r][b*HALF_W +: HALF_W] <= wr_data[b*HALF_W +: HALF_W];
        end

        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
          !(wr_en && wr_idx == SEL_W'(r) && wr_be[b])
          |=> $stable(regs_q[r][b*HALF_W +: HALF_W])); // R3
      end
    end
  endgenerate

  assign rd_word = regs_q[rd_idx];
endmodule

// File: rtl/abus_slave.sv
`timescale 1ns/1ps
module abus_slave
  import abus_pkg::*;
#(
  parameter int STRETCH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_pri_n,
  input  logic              cs_sec_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              a0,
  inout  wire  [WORD_W-1:0] dbus,
  input  logic              ext_wait_n,
  output logic              wait_n
);
  localparam int HALF_W = WORD_W / 2;

  logic              cs_any;
  logic              rd_qual;
  logic              wr_s;
  logic              wr_d;
  logic              wr_rise;
  wr_snap_t          snap_q;
  logic              commit;
  logic [1:0]        be;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] bus_out;
  logic              stretch;

  assign cs_any  = ~cs_pri_n | ~cs_sec_n;
  assign rd_qual = cs_any & ~rd_n;

  // Bring the write strobe into the local clock domain; idle level is high.
  abus_sync #(.WIDTH(1), .RESET_VAL(1'b1)) i_wr_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(wr_n),
    .q_sync (wr_s)
  );

  assign wr_rise = wr_s & ~wr_d;

  // Snapshot the cycle while the synchronised strobe is low; the bus is stable then.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d   <= 1'b1;
      snap_q <= '0;
    end else begin
      wr_d <= wr_s;
      if (!wr_s) begin
        snap_q.pri  <= ~cs_pri_n;
        snap_q.sec  <= ~cs_sec_n;
        snap_q.idx  <= reg_sel;
        snap_q.a0   <= a0;
        snap_q.lane <= {~lane_hi_n, ~lane_lo_n};
        snap_q.data <= dbus;
      end
    end
  end

  assign commit = wr_rise & (snap_q.pri | snap_q.sec);

  // Primary region takes precedence; secondary steers its byte by A0.
  always_comb begin
    if (snap_q.pri) begin
      be    = snap_q.lane;
      wdata = snap_q.data;
    end else begin
      be    = snap_q.a0 ? 2'b10 : 2'b01;
      wdata = {snap_q.data[HALF_W-1:0], snap_q.data[HALF_W-1:0]};
    end
  end

  abus_regfile #(.SEL_W(SEL_W), .WORD_W(WORD_W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (commit),
    .wr_idx (snap_q.idx),
    .wr_be  (be),
    .wr_data(wdata),
    .rd_idx (reg_sel),
    .rd_word(rd_word)
  );

  always_comb begin
    if (!cs_pri_n)
      bus_out = rd_word;
    else
      bus_out = {{HALF_W{1'b0}}, a0 ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0]};
  end

  assign dbus = rd_qual ? bus_out : {WORD_W{1'bz}};

  abus_stretch #(.STRETCH_CYC(STRETCH_CYC)) i_stretch (
    .clk      (clk),
    .rst      (rst),
    .acc_async(~cs_pri_n & (~rd_n | ~wr_n)),
    .stretch  (stretch)
  );

  assign wait_n = ext_wait_n & ~stretch;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wait_n == ext_wait_n)); // R11
endmodule

// File: tb/test_abus_slave.sv
`timescale 1ns/1ps
module test_abus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_pri_n = 1'b1, cs_sec_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        lane_lo_n = 1'b1, lane_hi_n = 1'b1, a0 = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        ext_wait_n = 1'b1;
  logic        tb_drv = 1'b0;
  logic [15:0] tb_data = '0;
  wire  [15:0] dbus;
  logic        wait_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];

  assign dbus = tb_drv ? tb_data : 16'hzzzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  abus_slave #(.STRETCH_CYC(STRETCH)) i_abus_slave (
    .clk(clk), .rst(rst), .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n),
    .rd_n(rd_n), .wr_n(wr_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .reg_sel(reg_sel), .a0(a0), .dbus(dbus), .ext_wait_n(ext_wait_n),
    .wait_n(wait_n)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // pri=1 primary region, pri=0 secondary; lanes given active-low
  task automatic bus_write(bit pri, bit nocs, logic [2:0] sel, bit a, bit lo_n, bit hi_n,
                           logic [15:0] d);
    @(negedge clk);
    cs_pri_n = nocs ? 1'b1 : ~pri; cs_sec_n = nocs ? 1'b1 : pri;
    reg_sel = sel; a0 = a; lane_lo_n = lo_n; lane_hi_n = hi_n;
    tb_data = d; tb_drv = 1'b1; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(3);
    cs_pri_n = 1'b1; cs_sec_n = 1'b1; tb_drv = 1'b0; lane_lo_n = 1'b1; lane_hi_n = 1'b1;
    idle(4);
  endtask

  task automatic bus_read(bit pri, logic [2:0] sel, bit a, output logic [15:0] d);
    @(negedge clk);
    cs_pri_n = ~pri; cs_sec_n = pri; reg_sel = sel; a0 = a; rd_n = 1'b0;
    #1 d = dbus;
    idle(2);
    rd_n = 1'b1; cs_pri_n = 1'b1; cs_sec_n = 1'b1;
    idle(10);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R11 wait idle", {15'd0, wait_n}, 16'd1);
    for (int i = 0; i < 8; i++) begin
      bus_read(1'b1, 3'(i), 1'b0, v);
      check("R11 reg zero", v, 16'h0000);
    end
  endtask

  task automatic t_full_words;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      model[i] = 16'h1111 * 16'(i + 1) ^ 16'h5A00;
      bus_write(1'b1, 1'b0, 3'(i), 1'b0, 1'b0, 1'b0, model[i]);
    end
    for (int i = 7; i >= 0; i--) begin
      bus_read(1'b1, 3'(i), 1'b0, v);
      check("R2 R6 R7 word select", v, model[i]);
    end
  endtask

  task automatic t_lanes;
    logic [15:0] v;
    bus_write(1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 16'hDEAD);
    model[2][7:0] = 8'hAD;
    bus_read(1'b1, 3'd2, 1'b0, v);
    check("R3 low lane only", v, model[2]);
    bus_write(1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    model[2][15:8] = 8'hBE;
    bus_read(1'b1, 3'd2, 1'b0, v);
    check("R3 high lane only", v, model[2]);
    bus_write(1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h0000);
    bus_read(1'b1, 3'd2, 1'b0, v);
    check("R4 no lane", v, model[2]);
  endtask

  task automatic t_no_cs;
    logic [15:0] v;
    bus_write(1'b1, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 16'hFFFF);
    bus_read(1'b1, 3'd5, 1'b0, v);
    check("R1 write without chip select", v, model[5]);
  endtask

  task automatic t_byte_mode;
    logic [15:0] v;
    bus_write(1'b0, 1'b0, 3'd6, 1'b0, 1'b1, 1'b1, 16'h7733);
    model[6][7:0] = 8'h33;
    bus_write(1'b0, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 16'h88C4);
    model[6][15:8] = 8'hC4;
    bus_read(1'b1, 3'd6, 1'b0, v);
    check("R5 byte steer word", v, model[6]);
    bus_read(1'b0, 3'd6, 1'b0, v);
    check("R5 byte read a0=0", v, {8'h00, model[6][7:0]});
    bus_read(1'b0, 3'd6, 1'b1, v);
    check("R5 byte read a0=1", v, {8'h00, model[6][15:8]});
  endtask

  task automatic long_access(bit pri, output int lows);
    lows = 0;
    @(negedge clk);
    cs_pri_n = ~pri; cs_sec_n = pri; reg_sel = 3'd0; rd_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!wait_n) lows++;
    end
    rd_n = 1'b1; cs_pri_n = 1'b1; cs_sec_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!wait_n) lows++;
    end
  endtask

  task automatic t_stretch;
    int n;
    long_access(1'b1, n);
    check("R9 primary stretch length", 16'(n), 16'(STRETCH));
    long_access(1'b1, n);
    check("R9 second access restretches", 16'(n), 16'(STRETCH));
    long_access(1'b0, n);
    check("R10 secondary no stretch", 16'(n), 16'd0);
  endtask

  task automatic t_ext_wait;
    @(negedge clk);
    ext_wait_n = 1'b0;
    #1 check("R8 external wait passes", {15'd0, wait_n}, 16'd0);
    idle(1);
    ext_wait_n = 1'b1;
    #1 check("R8 external wait released", {15'd0, wait_n}, 16'd1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_full_words();
    t_lanes();
    t_no_cs();
    t_byte_mode();
    t_stretch();
    t_ext_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule